// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses the direction of conditional branches from two pieces of information. The first is the address of the branch. The second is the outcome of the two branches that resolved most recently. A 2-bit global history register holds those two outcomes. Its value selects one of four tables, and each table holds sixteen 2-bit saturating counters. Address bits 5 down to 2 pick the counter within the selected table. The counter's upper bit is the guess.

The predict side is purely combinational. A fetch address presented on `pred_pc` yields `pred_taken` in the same cycle, read from the table that the current history selects. The update side takes a resolved branch address together with its real outcome. On the clock edge it moves one counter in the direction of that outcome, in the table that the history selected before this update. The history then shifts, and the new outcome enters at bit 0. The history changes only at resolution. The block computes no target address and makes no speculative history repair.

Top module: `corr_predictor`

## Requirements
- R1: After reset every counter in every table holds 01 and the history holds 00, so every fetch address is predicted not-taken.
- R2: `pred_taken` follows `pred_pc` combinationally in the same cycle. Only `pred_pc[5:2]` selects the entry, and the other address bits have no effect on the prediction.
- R3: A counter value of 10 or 11 predicts taken, and a counter value of 00 or 01 predicts not-taken.
- R4: A counter that holds 11 needs two not-taken updates in a row before its prediction flips to not-taken. After one such update it holds 10 and still predicts taken.
- R5: A counter stays at 11 on a taken update and stays at 00 on a not-taken update. It does not wrap in either direction.
- R6: Each accepted update shifts the history left by one place, and the actual outcome (1 = taken) enters bit 0. History 01 therefore means the older branch was not taken and the newest branch was taken. The history value selects the table used for prediction.
- R7: An update changes only the counter at `upd_pc[5:2]` in the table selected by the history. Counters in the other three tables and at other entries keep their values.
- R8: The table that an update writes is chosen by the history as it stood before that update. The shift of the history takes effect after the counter write.
- R9: While `upd_valid` is low, neither the counters nor the history change, whatever `upd_pc` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 32 | Fetch address to be predicted |
| pred_taken | output | 1 | Prediction for `pred_pc`: 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch: 1 = taken |

## Verification
The bench trains one entry under a changing history. It reads the same address back under each history value, which shows that training lands in a single table. A design that ignored the history, or that wrote with the history as it stood after the shift, would show a trained counter in the wrong place. It drives a counter past 11 and below 00 and then steps it back. A counter that wraps instead of saturating ends up on the opposite side of the threshold, and a design without hysteresis flips its prediction after a single miss. It also holds junk on the update inputs while `upd_valid` is low, and it applies a second reset after training. Either an update that leaked through or a counter that survived the reset would then be visible in the predictions.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
    localparam int unsigned PC_W    = 32;
    localparam int unsigned HIST_W  = 2;
    localparam int unsigned IDX_W   = 4;
    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned CNT_W   = 2;

    typedef logic [PC_W-1:0] pc_t;
endpackage

// File: rtl/corr_sat.sv
module corr_sat #(
    parameter int unsigned CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  logic                taken,
    output logic [CTR_BITS-1:0] nxt
);
    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
    localparam logic [CTR_BITS-1:0] CTR_MIN = '0;
    localparam logic [CTR_BITS-1:0] ONE     = 1;

    always_comb begin
        if (taken) begin
            nxt = (cur == CTR_MAX) ? cur : cur + ONE;
        end else begin
            nxt = (cur == CTR_MIN) ? cur : cur - ONE;
        end
    end
endmodule

// File: rtl/corr_hist.sv
module corr_hist #(
    parameter int unsigned HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 outcome,
    output logic [HIST_BITS-1:0] hist
);
    typedef struct packed {
        logic [HIST_BITS-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hist = {st_q.hist[HIST_BITS-2:0], outcome};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hist <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.hist;
endmodule

// File: rtl/corr_tables.sv
module corr_tables #(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned IDX_BITS  = 4,
    parameter int unsigned CTR_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HIST_BITS-1:0] rd_tab,
    input  logic [IDX_BITS-1:0]  rd_idx,
    output logic [CTR_BITS-1:0]  rd_ctr,
    input  logic                 wr_en,
    input  logic [HIST_BITS-1:0] wr_tab,
    input  logic [IDX_BITS-1:0]  wr_idx,
    input  logic                 wr_taken
);
    localparam int unsigned NTAB = 1 << HIST_BITS;
    localparam int unsigned NENT = 1 << IDX_BITS;
    localparam logic [CTR_BITS-1:0] CTR_INIT = {1'b0, {(CTR_BITS-1){1'b1}}};

    typedef struct packed {
        logic [NTAB-1:0][NENT-1:0][CTR_BITS-1:0] ctr;
    } tab_state_t;

    tab_state_t st_d, st_q;

    logic [NTAB-1:0][CTR_BITS-1:0] tab_rd;
    logic [CTR_BITS-1:0]           wr_cur;
    logic [CTR_BITS-1:0]           wr_nxt;

    for (genvar t = 0; t < NTAB; t++) begin : g_tab_rd
        assign tab_rd[t] = st_q.ctr[t][rd_idx];
    end

    assign rd_ctr = tab_rd[rd_tab];
    assign wr_cur = st_q.ctr[wr_tab][wr_idx];

    corr_sat #(.CTR_BITS(CTR_BITS)) u_sat (
        .cur   (wr_cur),
        .taken (wr_taken),
        .nxt   (wr_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_tab][wr_idx] = wr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr <= {(NTAB*NENT){CTR_INIT}};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/corr_predictor.sv
module corr_predictor
    import corr_bp_pkg::*;
#(
    parameter int unsigned HIST_BITS = HIST_W,
    parameter int unsigned IDX_BITS  = IDX_W,
    parameter int unsigned IDX_BASE  = IDX_LSB,
    parameter int unsigned CTR_BITS  = CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int unsigned IDX_TOP = IDX_BASE + IDX_BITS;

    logic [HIST_BITS-1:0] hist_cur;
    logic [IDX_BITS-1:0]  rd_idx;
    logic [IDX_BITS-1:0]  wr_idx;
    logic [CTR_BITS-1:0]  rd_ctr;
    logic                 unused_pc_bits;

    assign rd_idx = pred_pc[IDX_BASE +: IDX_BITS];
    assign wr_idx = upd_pc[IDX_BASE +: IDX_BITS];
    assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_TOP], pred_pc[IDX_BASE-1:0],
                              upd_pc[PC_W-1:IDX_TOP],  upd_pc[IDX_BASE-1:0]};

    corr_hist #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .hist     (hist_cur)
    );

    corr_tables #(
        .HIST_BITS (HIST_BITS),
        .IDX_BITS  (IDX_BITS),
        .CTR_BITS  (CTR_BITS)
    ) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_tab   (hist_cur),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_tab   (hist_cur),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    assign pred_taken = rd_ctr[CTR_BITS-1];
endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned PCW       = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PCW-1:0]       pred_pc,
    input logic                 pred_taken,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic [HIST_BITS-1:0] hist
);
    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist[0] == $past(upd_taken)); // R6

    AST_HIST_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0])); // R6

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist)); // R9

    AST_PRED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!upd_valid) && pred_pc == $past(pred_pc)) |-> pred_taken == $past(pred_taken)); // R9
endmodule

bind corr_predictor corr_predictor_chk #(
    .HIST_BITS (HIST_BITS),
    .PCW       (corr_bp_pkg::PC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .hist       (hist_cur)
);

// File: tb/corr_predictor_bench.sv
`timescale 1ns/1ps
module corr_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [31:0] PC_A = 32'h0000_0040; // index 0
    localparam logic [31:0] PC_B = 32'h0000_0044; // index 1
    localparam logic [31:0] PC_C = 32'h0000_0048; // index 2
    localparam logic [31:0] PC_D = 32'h0000_004C; // index 3

    always #2.5 clk = ~clk;

    corr_predictor u_corr_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    task automatic chk(input logic [31:0] pc, input logic exp, input string req);
        pred_pc = pc;
        #1;
        checks++;
        if (pred_taken !== exp) begin
            failures++;
            $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, pred_taken, exp);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        chk(32'h0000_0000, 1'b0, "R1");
        chk(32'h0000_003C, 1'b0, "R1");
        chk(32'h0000_1234, 1'b0, "R1");
    endtask

    // history 00 -> 01 -> 11, one table written per update
    task automatic t_table_select();
        upd(PC_A, 1'b1);                     // t0[0]=10, h=01
        chk(PC_A, 1'b0, "R7");               // t1[0]=01
        upd(PC_A, 1'b1);                     // t1[0]=10, h=11
        chk(PC_A, 1'b0, "R8");               // t3[0]=01 untouched
        upd(PC_A, 1'b1);                     // t3[0]=10
        chk(PC_A, 1'b1, "R3");
        chk(PC_A | 32'hFFFF_F003, 1'b1, "R2");
        chk(PC_B, 1'b0, "R7");               // t3[1]=01
    endtask

    task automatic t_upper_sat_hysteresis();
        upd(PC_A, 1'b1);                     // t3[0]=11
        upd(PC_A, 1'b1);                     // stays 11
        chk(PC_A, 1'b1, "R5");
        upd(PC_A, 1'b0);                     // t3[0]=10, h=10
        chk(PC_A, 1'b0, "R6");               // t2[0]=01
        upd(PC_B, 1'b1);                     // t2[1]=10, h=01
        chk(PC_A, 1'b1, "R6");               // t1[0]=10
        upd(PC_B, 1'b1);                     // t1[1]=10, h=11
        chk(PC_A, 1'b1, "R4");               // t3[0]=10 still taken
        upd(PC_A, 1'b0);                     // t3[0]=01, h=10
        upd(PC_B, 1'b1);                     // t2[1]=11, h=01
        upd(PC_B, 1'b1);                     // t1[1]=11, h=11
        chk(PC_A, 1'b0, "R4");
    endtask

    task automatic t_invalid_ignored();
        @(negedge clk);
        upd_valid = 1'b0;
        upd_pc    = PC_B;
        upd_taken = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(PC_B, 1'b0, "R9");               // h still 11 -> t3[1]=01
        @(negedge clk);
        upd_pc    = PC_A;
        upd_taken = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(PC_A, 1'b0, "R9");               // t3[0] still 01
    endtask

    task automatic t_lower_sat();
        upd(PC_C, 1'b0);                     // t3[2]=00, h=10
        upd(PC_C, 1'b0);                     // t2[2]=00, h=00
        upd(PC_C, 1'b0);                     // t0[2]=00
        upd(PC_C, 1'b0);                     // t0[2] stays 00
        upd(PC_C, 1'b1);                     // t0[2]=01, h=01
        upd(PC_D, 1'b0);                     // h=10
        upd(PC_D, 1'b0);                     // h=00
        chk(PC_C, 1'b0, "R5");
        upd(PC_C, 1'b1);                     // t0[2]=10, h=01
        upd(PC_D, 1'b0);                     // h=10
        upd(PC_D, 1'b0);                     // h=00
        chk(PC_C, 1'b1, "R5");
    endtask

    task automatic t_reset_again();
        do_reset();
        chk(PC_A, 1'b0, "R1");
        chk(PC_B, 1'b0, "R1");
        chk(PC_C, 1'b0, "R1");
        upd(PC_D, 1'b1);                     // t0[3]=10, h=01
        chk(PC_D, 1'b0, "R1");               // history restarted at 00
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_table_select();
        t_upper_sat_hysteresis();
        t_invalid_ignored();
        t_lower_sat();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule